// File: doc/BRIEF.md
# Dual-Format Data Protection Guard CRC

This engine computes the guard field used in end-to-end data protection over a byte stream delivered one byte per clock. Each byte arrives with a valid strobe and with markers that open and close a span. A format select, taken on the opening byte, picks either a 16-bit guard or a 64-bit guard. The 16-bit guard is non-reflected and starts from zero. The 64-bit guard is reflected, starts from all ones and is inverted on delivery. One cycle after the closing byte, the finished guard appears on the output together with a one-cycle done pulse.

A span can also pick up where the previous one stopped. When the chain input is high on the opening byte, the engine seeds itself from the last guard it delivered. That guard is complemented first in 64-bit mode and used as it is in 16-bit mode. In this way a guard computed over a data block can be extended over a few trailing metadata bytes, and the result equals a single guard taken over both spans joined together. Each byte is processed by an unrolled bitwise update, so no lookup table is needed.

Top module: `guard_crc_engine`

## Requirements
- R1: With fmt_sel=0 on the opening byte, the guard is computed with polynomial 0x8BB7 and initial value 0x0000. Each byte is taken MSB-first and there is no final inversion. The 16-bit result sits in out_guard[15:0], with out_guard[63:16] equal to zero. For the ASCII bytes "123456789" the result is 0xD0DB.
- R2: With fmt_sel=1 on the opening byte, the guard uses the reflected polynomial 0x9A6C9329AC4BC9B5 and initial value all ones. Each byte is taken LSB-first and the register is inverted on delivery. For "123456789" the result is 0xAE8B14860A799888.
- R3: A 16-bit guard over 512 zero bytes is 0x0000. A 64-bit guard over 4096 zero bytes is 0x6482D367EB22B64E.
- R4: The format is captured on the opening byte (in_start=1). fmt_sel and chain have no effect on any other byte of the span.
- R5: out_done is high for exactly one cycle, in the cycle after a valid byte with in_last=1, and at no other time.
- R6: out_guard changes only in a cycle in which out_done is high, and holds its value otherwise.
- R7: When chain=1 on the opening byte, the span continues from the last delivered guard, and the new guard equals the guard of the previous span's bytes followed by this span's bytes. When chain=0 on the opening byte, the span starts fresh.
- R8: In a cycle with in_valid=0, in_byte, in_start and in_last are ignored.
- R9: After reset, out_done is 0 and out_guard is 0.
- R10: A byte carrying both in_start and in_last forms a one-byte span. A byte with in_start discards any span that has not been closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte and the markers are meaningful this cycle |
| in_start | input | 1 | First byte of a span |
| in_last | input | 1 | Final byte of a span |
| in_byte | input | 8 | Data byte |
| fmt_sel | input | 1 | Guard format on the opening byte: 0 = 16-bit, 1 = 64-bit |
| chain | input | 1 | On the opening byte, continue from the last delivered guard |
| out_guard | output | 64 | Last finished guard; 16-bit results are zero-extended |
| out_done | output | 1 | One-cycle pulse when out_guard is updated |

## Verification
The in-RTL properties check, on every cycle, four things. The done pulse must follow a closing byte and nothing else. The output must hold between pulses. A 16-bit result must have clean upper bits. An idle cycle must leave the running register untouched. Whether the guard values are arithmetically correct can only be shown by the bench scenarios. These include the published check strings in both formats, the all-zero blocks, chained spans compared against a guard over the joined bytes, format and chain toggling in the middle of a span, idle gaps carrying garbage markers, single-byte spans, and an abandoned span.

// File: rtl/grd_pkg.sv
package grd_pkg;

    localparam int GRD_W     = 64;
    localparam int GRD_NW    = 16;
    localparam int GRD_BYTE  = 8;

    localparam logic [GRD_NW-1:0] GRD_POLY_N = 16'h8BB7;
    localparam logic [GRD_W-1:0]  GRD_POLY_W = 64'h9A6C9329AC4BC9B5;

    typedef enum logic {
        GRD_FMT_N = 1'b0,
        GRD_FMT_W = 1'b1
    } grd_fmt_e;

    typedef struct packed {
        logic [GRD_W-1:0] crc;
        grd_fmt_e         fmt;
    } grd_state_t;

    // One byte, MSB first, left-shifting register.
    function automatic logic [GRD_NW-1:0] grd_step_n(input logic [GRD_NW-1:0] c_in,
                                                     input logic [GRD_BYTE-1:0] b);
        logic [GRD_NW-1:0] c;
        logic fb;
        c = c_in;
        for (int i = GRD_BYTE - 1; i >= 0; i--) begin
            fb = c[GRD_NW-1] ^ b[i];
            c  = {c[GRD_NW-2:0], 1'b0};
            if (fb) c = c ^ GRD_POLY_N;
        end
        return c;
    endfunction

    // One byte, LSB first, right-shifting register.
    function automatic logic [GRD_W-1:0] grd_step_w(input logic [GRD_W-1:0] c_in,
                                                    input logic [GRD_BYTE-1:0] b);
        logic [GRD_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = 0; i < GRD_BYTE; i++) begin
            fb = c[0] ^ b[i];
            c  = c >> 1;
            if (fb) c = c ^ GRD_POLY_W;
        end
        return c;
    endfunction

endpackage

// File: rtl/guard_step.sv
module guard_step
    import grd_pkg::*;
#(
    parameter int W = GRD_W,
    parameter int B = GRD_BYTE
) (
    input  logic [W-1:0] crc_in,
    input  logic [B-1:0] data,
    input  grd_fmt_e     fmt,
    output logic [W-1:0] crc_out
);
    localparam int PAD = W - GRD_NW;

    logic [W-1:0] nxt_w;
    logic [W-1:0] nxt_n;

    always_comb begin
        nxt_w = grd_step_w(crc_in, data);
        nxt_n = {{PAD{1'b0}}, grd_step_n(crc_in[GRD_NW-1:0], data)};
        crc_out = (fmt == GRD_FMT_W) ? nxt_w : nxt_n;
    end
endmodule

// File: rtl/guard_seed.sv
module guard_seed
    import grd_pkg::*;
#(
    parameter int W = GRD_W
) (
    input  grd_fmt_e     fmt,
    input  logic         chain,
    input  logic [W-1:0] held,
    output logic [W-1:0] seed
);
    localparam int PAD = W - GRD_NW;

    always_comb begin
        unique case ({fmt == GRD_FMT_W, chain})
            2'b00:   seed = '0;
            2'b01:   seed = {{PAD{1'b0}}, held[GRD_NW-1:0]};
            2'b10:   seed = '1;
            default: seed = ~held;
        endcase
    end
endmodule

// File: rtl/guard_crc_engine.sv
module guard_crc_engine
    import grd_pkg::*;
#(
    parameter int W = GRD_W,
    parameter int B = GRD_BYTE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_start,
    input  logic         in_last,
    input  logic [B-1:0] in_byte,
    input  logic         fmt_sel,
    input  logic         chain,
    output logic [W-1:0] out_guard,
    output logic         out_done
);
    grd_state_t   run_q;
    grd_fmt_e     res_fmt_q;
    grd_fmt_e     fmt_eff;
    logic [W-1:0] seed;
    logic [W-1:0] cur;
    logic [W-1:0] nxt;

    guard_seed #(.W(W)) u_seed (
        .fmt   (grd_fmt_e'(fmt_sel)),
        .chain (chain),
        .held  (out_guard),
        .seed  (seed)
    );

    always_comb begin
        fmt_eff = in_start ? grd_fmt_e'(fmt_sel) : run_q.fmt;
        cur     = in_start ? seed : run_q.crc;
    end

    guard_step #(.W(W), .B(B)) u_step (
        .crc_in  (cur),
        .data    (in_byte),
        .fmt     (fmt_eff),
        .crc_out (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '{crc: '0, fmt: GRD_FMT_N};
            res_fmt_q <= GRD_FMT_N;
            out_guard <= '0;
            out_done  <= 1'b0;
        end else begin
            out_done <= in_valid && in_last;
            if (in_valid) begin
                run_q.crc <= nxt;
                run_q.fmt <= fmt_eff;
                if (in_last) begin
                    out_guard <= (fmt_eff == GRD_FMT_W) ? ~nxt : nxt;
                    res_fmt_q <= fmt_eff;
                end
            end
        end
    end

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> out_done);

    p_done_cause_r5: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid && in_last));

    p_guard_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> $stable(out_guard));

    p_narrow_clean_r1: assert property (@(posedge clk) disable iff (rst)
        (out_done && res_fmt_q == GRD_FMT_N) |-> (out_guard[W-1:GRD_NW] == '0));

    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(run_q) && $stable(out_guard)));

endmodule

// File: tb/tb_guard_crc_engine.sv
module tb_guard_crc_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic        in_last = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        fmt_sel = 1'b0;
    logic        chain = 1'b0;
    logic [63:0] out_guard;
    logic        out_done;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp = '0;

    always #10 clk = ~clk;

    guard_crc_engine dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_byte(in_byte), .fmt_sel(fmt_sel), .chain(chain),
        .out_guard(out_guard), .out_done(out_done)
    );

    function automatic logic [63:0] ref_n(input byte unsigned d[$]);
        logic [15:0] c = 16'h0000;
        logic fb;
        foreach (d[k]) begin
            for (int i = 7; i >= 0; i--) begin
                fb = c[15] ^ d[k][i];
                c = c << 1;
                if (fb) c = c ^ 16'h8BB7;
            end
        end
        return {48'h0, c};
    endfunction

    function automatic logic [63:0] ref_w(input byte unsigned d[$]);
        logic [63:0] c = '1;
        logic fb;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ d[k][i];
                c = c >> 1;
                if (fb) c = c ^ 64'h9A6C9329AC4BC9B5;
            end
        end
        return ~c;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected guard, then streams the span. fmt_sel and
    // chain are inverted on non-opening bytes (R4); idle gaps carry garbage (R8).
    task automatic send(input logic f, input logic ch, input byte unsigned d[$],
                        input int gap, input logic [63:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        last_exp = exp;
        for (int i = 0; i < d.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_last  = (i == d.size() - 1);
            in_byte  = d[i];
            fmt_sel  = (i == 0) ? f : ~f;
            chain    = (i == 0) ? ch : ~ch;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1;
                in_byte = 8'hA5; fmt_sel = ~f; chain = ~ch;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_done) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5: unexpected done, actual %h expected none", out_guard);
            end else begin
                check(tag_q.pop_front(), out_guard, exp_q.pop_front());
            end
        end
    end

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        byte unsigned s[$];
        byte unsigned z[$];
        byte unsigned a[$];
        byte unsigned b[$];
        byte unsigned ab[$];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset guard", out_guard, 64'h0);
        check("R9 reset done", {63'h0, out_done}, 64'h0);

        s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send(1'b0, 1'b0, s, 0, 64'h000000000000D0DB, "R1 check string");
        send(1'b1, 1'b0, s, 0, 64'hAE8B14860A799888, "R2 check string");
        send(1'b1, 1'b0, s, 2, 64'hAE8B14860A799888, "R8 gaps with garbage");

        z = {};
        for (int i = 0; i < 512; i++) z.push_back(8'h00);
        send(1'b0, 1'b0, z, 0, 64'h0, "R3 zero block narrow");
        for (int i = 0; i < 3584; i++) z.push_back(8'h00);
        send(1'b1, 1'b0, z, 0, 64'h6482D367EB22B64E, "R3 zero block wide");

        a = {};
        for (int i = 0; i < 32; i++) a.push_back(byte'((i * 37 + 11) & 8'hFF));
        b = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01, 8'h80, 8'h7F, 8'h55};
        ab = {a, b};
        send(1'b0, 1'b0, a, 0, ref_n(a), "R1 R4 data narrow");
        send(1'b0, 1'b1, b, 0, ref_n(ab), "R7 chain narrow");
        send(1'b1, 1'b0, a, 1, ref_w(a), "R2 R4 data wide");
        send(1'b1, 1'b1, b, 0, ref_w(ab), "R7 chain wide");
        send(1'b1, 1'b0, b, 0, ref_w(b), "R7 fresh after chain");

        repeat (6) @(negedge clk);
        check("R6 hold between pulses", out_guard, last_exp);

        s = '{8'h5A};
        send(1'b1, 1'b0, s, 0, ref_w(s), "R10 single byte wide");
        send(1'b0, 1'b0, s, 0, ref_n(s), "R10 single byte narrow");

        // abandoned span: three bytes, no closing marker
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = (i == 0); in_last = 1'b0;
            in_byte = 8'hC3; fmt_sel = 1'b1; chain = 1'b0;
        end
        send(1'b0, 1'b0, b, 0, ref_n(b), "R10 restart discards open span");

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: missing done, actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule